// File: doc/BRIEF.md
# Carry-Less Multiply and Pack Unit

This unit is a 64-bit execution block for bit-manipulation work used in cryptographic code. It computes carry-less (XOR) products of two operands and returns one of three 64-bit slices of the 128-bit result: the low half, the high half, or the reversed slice. It also merges fields of two operands into one word. The multiply runs one multiplier bit per cycle on a shift-and-XOR datapath. Each pack operation finishes in a single cycle.

A caller presents `start` with an opcode and two operands while the unit is idle. A multiply raises `busy` until the product is ready. Every operation ends with a one-cycle `done` pulse, and `result` changes in that same cycle. `result` then holds its value until the next operation completes. The unit accumulates the whole 128-bit product and picks the requested slice only in the final cycle. The high slice is formed from the reversed slice shifted right by one bit.

Top module: `clmul_pack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy`=0, `done`=0 and `result`=0.
- R2: Opcode 0 returns bits 63:0 of the 128-bit carry-less product of `a` and `b`.
- R3: Opcode 1 returns bits 127:64 of the carry-less product. This equals the opcode-2 value shifted right logically by one bit.
- R4: Opcode 2 returns bits 126:63 of the carry-less product.
- R5: A multiply (opcodes 0 to 2) accepted at clock edge t holds `busy` high from edge t until edge t+64. At edge t+64, `busy` falls, and `done` pulses for one cycle together with the result.
- R6: A `start` sampled while `busy` is high is ignored. This includes the edge at which the multiply completes. The running multiply keeps its operands and timing, and no extra `done` pulse appears.
- R7: Opcode 3 returns `a[31:0]` in bits 31:0 and `b[31:0]` in bits 63:32.
- R8: Opcode 4 returns `a[7:0]` in bits 7:0 and `b[7:0]` in bits 15:8, with bits 63:16 zero.
- R9: Opcode 5 returns `a[15:0]` in bits 15:0 and `b[15:0]` in bits 31:16, with bit 31 copied into bits 63:32.
- R10: A pack or reserved opcode accepted at edge t pulses `done` at edge t. `busy` stays low, so such operations can be issued on back-to-back cycles.
- R11: Opcodes 6 and 7 are reserved: they complete like a pack with a zero result. `result` changes only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation; honoured only while idle |
| op | input | 3 | Opcode: 0 low, 1 high, 2 reversed, 3 half pack, 4 byte pack, 5 sign-extending pack, 6/7 reserved |
| a | input | 64 | First operand (multiplicand / low field source) |
| b | input | 64 | Second operand (multiplier / high field source) |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Registered result, held between completions |

## Verification
A fault in the iteration counter shows up first as `busy` falling or `done` pulsing on the wrong cycle. The per-cycle comparison catches this in the exact cycle of the error, which is at most 64 cycles after the start. A fault in the multiplicand shift or the accumulator feedback produces no visible symptom until completion. It then appears as a wrong slice for some operand pattern. The bench therefore uses all-ones operands, single top-bit operands and dense values, so that every product bit and the bit-63 boundary between slices are exercised. If a start issued while busy is wrongly accepted, the result changes or an extra `done` appears within the same multiply window.

// File: rtl/clp_pkg.sv
package clp_pkg;

  typedef enum logic [2:0] {
    OP_CLMUL_LO  = 3'd0,
    OP_CLMUL_HI  = 3'd1,
    OP_CLMUL_REV = 3'd2,
    OP_PACK_HALF = 3'd3,
    OP_PACK_BYTE = 3'd4,
    OP_PACK_QSX  = 3'd5,
    OP_RSV6      = 3'd6,
    OP_RSV7      = 3'd7
  } clp_op_e;

  function automatic logic is_carryless(input clp_op_e o);
    return (o == OP_CLMUL_LO) || (o == OP_CLMUL_HI) || (o == OP_CLMUL_REV);
  endfunction

endpackage

// File: rtl/clp_clmul_core.sv
module clp_clmul_core #(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic              busy,
  output logic              fin_now,
  output logic [2*XLEN-1:0] prod_nx
);
  localparam int PW = 2 * XLEN;
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

  logic [PW-1:0]   acc_q;
  logic [PW-1:0]   mcand_q;
  logic [XLEN-1:0] mplier_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q;

  // XOR the shifted multiplicand in when the current multiplier bit is set
  assign prod_nx = mplier_q[0] ? (acc_q ^ mcand_q) : acc_q;
  assign fin_now = busy_q && (cnt_q == LAST);
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
    end else if (busy_q) begin
      acc_q    <= prod_nx;
      mcand_q  <= {mcand_q[PW-2:0], 1'b0};
      mplier_q <= {1'b0, mplier_q[XLEN-1:1]};
      cnt_q    <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (launch) begin
      acc_q    <= '0;
      mcand_q  <= {{XLEN{1'b0}}, a};
      mplier_q <= b;
      cnt_q    <= '0;
      busy_q   <= 1'b1;
    end
  end

  assert_launch_loads_R5: assert property (@(posedge clk) disable iff (rst)
    (launch && !busy_q) |=> (busy_q && cnt_q == '0));

  assert_count_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == CW'($past(cnt_q) + 1'b1)));

  assert_finish_idle_R5: assert property (@(posedge clk) disable iff (rst)
    fin_now |=> (!busy_q && !fin_now));

endmodule

// File: rtl/clp_slice_sel.sv
module clp_slice_sel import clp_pkg::*; #(
  parameter int XLEN = 64
) (
  input  clp_op_e           sel,
  input  logic [2*XLEN-1:0] prod,
  output logic [XLEN-1:0]   slice
);
  logic [XLEN-1:0] rev_w;
  logic [XLEN-1:0] hi_w;

  assign rev_w = prod[2*XLEN-2:XLEN-1];
  // high slice reuses the reversed wires; the top product bit fills bit XLEN-1
  assign hi_w  = {prod[2*XLEN-1], rev_w[XLEN-1:1]};

  always_comb begin
    case (sel)
      OP_CLMUL_HI:  slice = hi_w;
      OP_CLMUL_REV: slice = rev_w;
      default:      slice = prod[XLEN-1:0];
    endcase
  end
endmodule

// File: rtl/clp_pack_net.sv
module clp_pack_net import clp_pkg::*; #(
  parameter int XLEN = 64
) (
  input  clp_op_e               sel,
  input  logic [XLEN/2-1:0]     a_lo,
  input  logic [XLEN/2-1:0]     b_lo,
  output logic [XLEN-1:0]       packed_o
);
  localparam int HALF = XLEN / 2;
  localparam int QTR  = XLEN / 4;
  localparam int BYTE = 8;

  logic [HALF-1:0] qtr_pair;
  logic [XLEN-1:0] half_w, byte_w, qsx_w;

  assign half_w   = {b_lo, a_lo};
  assign byte_w   = {{(XLEN-2*BYTE){1'b0}}, b_lo[BYTE-1:0], a_lo[BYTE-1:0]};
  assign qtr_pair = {b_lo[QTR-1:0], a_lo[QTR-1:0]};
  assign qsx_w    = {{(XLEN-HALF){qtr_pair[HALF-1]}}, qtr_pair};

  always_comb begin
    case (sel)
      OP_PACK_HALF: packed_o = half_w;
      OP_PACK_BYTE: packed_o = byte_w;
      OP_PACK_QSX:  packed_o = qsx_w;
      default:      packed_o = '0;
    endcase
  end
endmodule

// File: rtl/clmul_pack_unit.sv
module clmul_pack_unit import clp_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;

  clp_op_e           op_e, op_q;
  logic              wants_mul, mul_go, fast_go;
  logic              core_busy, core_fin;
  logic [2*XLEN-1:0] core_prod;
  logic [XLEN-1:0]   slice_w, pack_w;
  logic              done_q;
  logic [XLEN-1:0]   res_q;

  assign op_e      = clp_op_e'(op);
  assign wants_mul = is_carryless(op_e);
  assign mul_go    = start && !core_busy && wants_mul;
  assign fast_go   = start && !core_busy && !wants_mul;

  clp_clmul_core #(.XLEN(XLEN)) u_core (
    .clk     (clk),
    .rst     (rst),
    .launch  (mul_go),
    .a       (a),
    .b       (b),
    .busy    (core_busy),
    .fin_now (core_fin),
    .prod_nx (core_prod)
  );

  clp_slice_sel #(.XLEN(XLEN)) u_slice (
    .sel   (op_q),
    .prod  (core_prod),
    .slice (slice_w)
  );

  clp_pack_net #(.XLEN(XLEN)) u_pack (
    .sel      (op_e),
    .a_lo     (a[HALF-1:0]),
    .b_lo     (b[HALF-1:0]),
    .packed_o (pack_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_CLMUL_LO;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (mul_go) op_q <= op_e;
      if (core_fin) begin
        done_q <= 1'b1;
        res_q  <= slice_w;
      end else if (fast_go) begin
        done_q <= 1'b1;
        res_q  <= pack_w;
      end
    end
  end

  assign busy   = core_busy;
  assign done   = done_q;
  assign result = res_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && result == '0));

  assert_pack_single_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op >= 3'd3) |=> (done && !busy));

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

// File: tb/sim_clmul_pack_unit.sv
`timescale 1ns/1ps
module sim_clmul_pack_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        busy, done;
  logic [63:0] result;

  always #4 clk = ~clk;

  clmul_pack_unit #(.XLEN(64)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
    .busy(busy), .done(done), .result(result)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  bit           m_busy = 0, m_done = 0;
  logic [63:0]  m_res = '0;
  int           m_cnt = 0;
  logic [127:0] m_prod = '0;
  logic [2:0]   m_op = '0;
  string        m_tag = "R11", m_ltag = "R10";
  bit           ign = 0;

  function automatic logic [127:0] clmul_ref(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] p = '0;
    for (int i = 0; i < 64; i++)
      if (y[i]) p = p ^ ({64'b0, x} << i);
    return p;
  endfunction

  function automatic logic [63:0] pack_ref(input logic [2:0] o, input logic [63:0] x, input logic [63:0] y);
    case (o)
      3'd3:    return {y[31:0], x[31:0]};
      3'd4:    return {48'b0, y[7:0], x[7:0]};
      3'd5:    return {{32{y[15]}}, y[15:0], x[15:0]};
      default: return 64'b0;
    endcase
  endfunction

  function automatic logic [63:0] slice_ref(input logic [2:0] o, input logic [127:0] p);
    case (o)
      3'd1:    return p[127:64];
      3'd2:    return p[126:63];
      default: return p[63:0];
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_res = '0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_res = slice_ref(m_op, m_prod);
        end
      end else if (start) begin
        m_op = op;
        if (op <= 3'd2) begin
          m_busy = 1; m_cnt = 64; m_prod = clmul_ref(a, b); m_ltag = "R5";
          m_tag = (op == 3'd0) ? "R2" : (op == 3'd1) ? "R3" : "R4";
        end else begin
          m_done = 1; m_res = pack_ref(op, a, b); m_ltag = "R10";
          m_tag = (op == 3'd3) ? "R7" : (op == 3'd4) ? "R8" : (op == 3'd5) ? "R9" : "R11";
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string tctl, tres;
    tctl = rst ? "R1" : ign ? "R6" : m_ltag;
    tres = rst ? "R1" : ign ? "R6" : (m_done ? m_tag : "R11");
    chk(tctl, {63'b0, busy}, {63'b0, m_busy});
    chk(tctl, {63'b0, done}, {63'b0, m_done});
    chk(tres, result, m_res);
  end

  function automatic logic [63:0] pat(input int i, input bit second);
    case (i)
      0: return 64'h0;
      1: return 64'hffff_ffff_ffff_ffff;
      2: return second ? 64'h8000_0000_0000_0000 : 64'h1;
      3: return 64'h8000_0000_0000_0001;
      4: return second ? 64'hfedc_ba98_7654_3210 : 64'h0123_4567_89ab_cdef;
      default: return second ? 64'h1357_9bdf_0246_8ace : 64'hdead_beef_f00d_cafe;
    endcase
  endfunction

  // issue one operation; mid > 0 adds an extra start that must be ignored (R6)
  task automatic run_op(input logic [2:0] o, input logic [63:0] x, input logic [63:0] y, input int mid);
    @(negedge clk); start = 1; op = o; a = x; b = y;
    @(negedge clk); start = 0;
    if (o <= 3'd2) begin
      for (int k = 1; k <= 68; k++) begin
        if (mid > 0 && k == mid) begin
          ign = 1; start = 1; op = 3'd3; a = ~x; b = ~y;
        end else begin
          start = 0;
        end
        @(negedge clk);
      end
      start = 0;
      ign = 0;
    end else begin
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 R3 R4 R5: carry-less slices over several operand patterns
    for (int o = 0; o < 3; o++)
      for (int i = 0; i < 6; i++)
        run_op(3'(o), pat(i, 0), pat(i, 1), 0);
    // R7 R8 R9 R11: pack and reserved opcodes
    for (int o = 3; o < 8; o++)
      for (int i = 0; i < 6; i++)
        run_op(3'(o), pat(i, 0), pat(i, 1), 0);
    // R9: explicit positive and negative sign cases
    run_op(3'd5, 64'h1111_2222_3333_7fff, 64'h4444_5555_6666_7abc, 0);
    run_op(3'd5, 64'h1111_2222_3333_0001, 64'h4444_5555_6666_8000, 0);
    // R6: start during a multiply and on the completing edge
    run_op(3'd0, pat(4, 0), pat(4, 1), 20);
    run_op(3'd2, pat(5, 0), pat(5, 1), 63);
    run_op(3'd1, pat(1, 0), pat(3, 1), 64);
    // R10: back-to-back single-cycle operations
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      start = 1; op = 3'(3 + (k % 5)); a = pat(k, 1); b = pat(k, 0);
      @(negedge clk);
    end
    start = 0;
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule